// File: doc/BRIEF.md
# Strap-Selected Parity Chain Test Mode

This block provides a manufacturing test mode for a pad ring. A set of N input pads is folded into one parity signal (the XOR of all of them), and that signal can replace the functional source of a single output pad. A tester can then prove that every input pad connects and switches by toggling the pads one at a time and watching the output pad flip.

The mode is chosen only when the functional reset `sys_rst_n` goes from low to high. At that moment the two strap pads are sampled. The straps are chain inputs 0 and 1. If both are low, the block enters test mode. If either is high, the block returns to normal mode. A power-on reset `por_n` always forces normal mode, whatever the straps are. Once test mode is active, the straps act as ordinary chain members. In normal mode the output pad carries the functional transmit signal `func_txd`.

The mode register is a two-state machine with states MODE_FUNC and MODE_TEST. On a reset release event (`sys_rst_n` high while it was low at the previous clock), there are two transitions. FUNC→TEST is taken when both straps are low. TEST→FUNC is taken when either strap is high. In every other cycle the state holds.

Top module: `xct_top`

## Requirements
- R1: When `sys_rst_n` is sampled high at a clock edge after being sampled low at the previous edge, and `chain_in[0]` and `chain_in[1]` are both low, the mode becomes TEST at that edge. This also holds when the mode is already TEST.
- R2: At such a release edge, if `chain_in[0]` or `chain_in[1]` is high, the mode becomes FUNC.
- R3: At any edge that is not a release edge, the mode does not change. This includes changes on the strap inputs while `sys_rst_n` stays high.
- R4: While `por_n` is low, the mode is FUNC immediately (asynchronously). After `por_n` rises with `sys_rst_n` already high, no release event is recognised until `sys_rst_n` has been low again.
- R5: In TEST mode, `pad_out` equals the XOR of all N bits of `chain_in`. With all bits low, `pad_out` is low.
- R6: In TEST mode, changing any single bit of `chain_in` inverts `pad_out`, whatever the order of the changes.
- R7: In TEST mode, an even number of high bits gives a low `pad_out`. This includes all N bits high with the default N=16.
- R8: In FUNC mode, `pad_out` equals `func_txd`, and changes on `chain_in` have no effect on `pad_out`.
- R9: In TEST mode, the strap bits `chain_in[0]` and `chain_in[1]` take part in the parity like every other bit.
- R10: Holding `sys_rst_n` low for any number of cycles leaves the mode unchanged until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; forces FUNC |
| sys_rst_n | input | 1 | Functional reset, active low; its release samples the straps |
| chain_in | input | N | Chain input pads; bits 0 and 1 are the straps |
| func_txd | input | 1 | Functional source for the output pad |
| pad_out | output | 1 | Output pad: parity in TEST, `func_txd` in FUNC |

## Verification
The hardest situation to reach is the mode transition itself. The mode is not visible at any port. It can only be inferred from `pad_out`. To make it visible, the bench holds the chain at even parity and sets `func_txd` high, so the two sources give opposite values. A low `pad_out` then proves TEST mode and a high `pad_out` proves FUNC mode. The bench pulses `sys_rst_n` with each strap combination. It asserts power-on reset while in TEST, then releases it with the functional reset already high, to show that no false release event is recognised.

// File: rtl/xct_pkg.sv
package xct_pkg;
    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_TEST = 1'b1
    } mode_e;
endpackage

// File: rtl/xct_mode_fsm.sv
module xct_mode_fsm
    import xct_pkg::*;
(
    input  logic  clk,
    input  logic  por_n,
    input  logic  sys_rst_n,
    input  logic  strap_a,
    input  logic  strap_b,
    output mode_e mode
);
    logic  rst_q;
    logic  release_evt;
    mode_e mode_nxt;

    // State register; power-on reset arms rst_q high so that a reset
    // already released at power-up is not seen as a release event.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_q <= 1'b1;
            mode  <= MODE_FUNC;
        end else begin
            rst_q <= sys_rst_n;
            mode  <= mode_nxt;
        end
    end

    always_comb begin
        release_evt = !rst_q && sys_rst_n;
        mode_nxt    = mode;
        if (release_evt) begin
            unique case (mode)
                MODE_FUNC: if (!strap_a && !strap_b) mode_nxt = MODE_TEST;
                MODE_TEST: if (strap_a || strap_b)   mode_nxt = MODE_FUNC;
            endcase
        end
    end

    a_r1_enter_on_low_straps: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_q && sys_rst_n && !strap_a && !strap_b) |=> (mode == MODE_TEST));

    a_r2_leave_on_high_strap: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_q && sys_rst_n && (strap_a || strap_b)) |=> (mode == MODE_FUNC));

    a_r3_hold_without_release: assert property (@(posedge clk) disable iff (!por_n)
        !(!rst_q && sys_rst_n) |=> $stable(mode));

    a_r10_hold_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> $stable(mode));

    // R4: power-on reset keeps the mode in FUNC
    a_r4_por_forces_func: assert property (@(posedge clk)
        !por_n |-> (mode == MODE_FUNC));
endmodule

// File: rtl/xct_chain.sv
module xct_chain #(
    parameter int N = 16
) (
    input  logic [N-1:0] din,
    output logic         parity
);
    localparam int LAST = N - 1;

    logic [N-1:0] link;

    assign link[0] = din[0];

    for (genvar i = 1; i < N; i++) begin : g_link
        assign link[i] = link[i-1] ^ din[i];
    end

    assign parity = link[LAST];
endmodule

// File: rtl/xct_pad_mux.sv
module xct_pad_mux
    import xct_pkg::*;
(
    input  mode_e mode,
    input  logic  chain_bit,
    input  logic  func_txd,
    output logic  pad_out
);
    always_comb begin
        unique case (mode)
            MODE_TEST: pad_out = chain_bit;
            MODE_FUNC: pad_out = func_txd;
        endcase
    end
endmodule

// File: rtl/xct_top.sv
module xct_top
    import xct_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         sys_rst_n,
    input  logic [N-1:0] chain_in,
    input  logic         func_txd,
    output logic         pad_out
);
    mode_e mode;
    logic  chain_bit;

    xct_mode_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .strap_a   (chain_in[0]),
        .strap_b   (chain_in[1]),
        .mode      (mode)
    );

    xct_chain #(.N(N)) u_chain (
        .din    (chain_in),
        .parity (chain_bit)
    );

    xct_pad_mux u_mux (
        .mode      (mode),
        .chain_bit (chain_bit),
        .func_txd  (func_txd),
        .pad_out   (pad_out)
    );

    a_r5_test_gives_parity: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MODE_TEST) |-> (pad_out == (^chain_in)));

    a_r8_func_gives_txd: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MODE_FUNC) |-> (pad_out == func_txd));

    a_r6_single_flip_inverts: assert property (@(posedge clk) disable iff (!por_n)
        ((mode == MODE_TEST) && $stable(mode) && ($countones(chain_in ^ $past(chain_in)) == 1))
        |-> (pad_out != $past(pad_out)));
endmodule

// File: tb/xct_top_tb.sv
module xct_top_tb;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         sys_rst_n = 1'b0;
    logic [N-1:0] chain_in = '0;
    logic         func_txd = 1'b1;
    logic         pad_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xct_top #(.N(N)) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .chain_in  (chain_in),
        .func_txd  (func_txd),
        .pad_out   (pad_out)
    );

    // {chain_in, func_txd, expected pad_out} in TEST mode
    localparam logic [N+1:0] TV [0:8] = '{
        {16'h0000, 1'b1, 1'b0},
        {16'hFFFF, 1'b0, 1'b0},
        {16'h0001, 1'b0, 1'b1},
        {16'h8000, 1'b0, 1'b1},
        {16'h0003, 1'b1, 1'b0},
        {16'h0002, 1'b0, 1'b1},
        {16'hA5A5, 1'b1, 1'b0},
        {16'h0007, 1'b0, 1'b1},
        {16'h7FFF, 1'b1, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pad_out=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] c, input logic t);
        @(negedge clk);
        chain_in = c;
        func_txd = t;
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_reset(input logic sa, input logic sb);
        @(negedge clk);
        sys_rst_n = 1'b0;
        chain_in  = {{(N-2){1'b0}}, sb, sa};
        @(posedge clk);
        @(negedge clk);
        sys_rst_n = 1'b1;
        @(posedge clk);
        #1;
        drive('0, 1'b1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: pad_out=%b expected=done", pad_out);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic exp;
        #3;
        check(pad_out, 1'b1, "R4 reset state FUNC");
        @(negedge clk);
        por_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(pad_out, 1'b1, "R10 held reset keeps FUNC");

        @(negedge clk);
        sys_rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(pad_out, 1'b0, "R1 enter TEST with straps low");

        // R5 R7 R9 table in TEST mode
        for (int k = 0; k < 9; k++) begin
            drive(TV[k][N+1:2], TV[k][1]);
            check(pad_out, TV[k][0], $sformatf("R5/R7/R9 vector %0d", k));
        end

        // R6 walk: high in descending order, then low in ascending order
        drive('0, 1'b0);
        exp = 1'b0;
        check(pad_out, exp, "R5 all low gives low");
        for (int i = N - 1; i >= 0; i--) begin
            chain_in[i] = 1'b1;
            drive(chain_in, 1'b0);
            exp = ~exp;
            check(pad_out, exp, $sformatf("R6 raise bit %0d", i));
        end
        check(pad_out, 1'b0, "R7 all high even N low");
        for (int i = 0; i < N; i++) begin
            chain_in[i] = 1'b0;
            drive(chain_in, 1'b0);
            exp = ~exp;
            check(pad_out, exp, $sformatf("R6 lower bit %0d", i));
        end

        pulse_reset(1'b0, 1'b0);
        check(pad_out, 1'b0, "R1 re-release straps low stays TEST");

        pulse_reset(1'b1, 1'b0);
        check(pad_out, 1'b1, "R2 strap a high leaves TEST");
        drive('0, 1'b0);
        check(pad_out, 1'b0, "R8 FUNC follows txd low");
        drive(16'h0001, 1'b0);
        check(pad_out, 1'b0, "R8 chain toggle ignored");
        drive(16'h5A3C, 1'b1);
        check(pad_out, 1'b1, "R8 chain pattern ignored");
        drive('0, 1'b1);
        check(pad_out, 1'b1, "R3 straps low without release stays FUNC");

        pulse_reset(1'b0, 1'b0);
        check(pad_out, 1'b0, "R1 enter again");
        pulse_reset(1'b0, 1'b1);
        check(pad_out, 1'b1, "R2 strap b high leaves TEST");

        pulse_reset(1'b0, 1'b0);
        check(pad_out, 1'b0, "R1 enter before POR");
        @(negedge clk);
        por_n = 1'b0;
        #1;
        check(pad_out, 1'b1, "R4 POR forces FUNC asynchronously");
        @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(pad_out, 1'b1, "R4 no false release after POR");
        drive(16'h0003, 1'b1);
        drive('0, 1'b1);
        check(pad_out, 1'b1, "R3 strap toggles with reset high ignored");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule